// File: doc/BRIEF.md
# Host Pause and Interrupt Controller

This block sits between a host register port and an embedded sequencer. It keeps a host control register that holds chip reset, interrupt enable, a pause request, an interrupt-line mode, a software interrupt and a power-down flag. It carries out the pause handshake with the sequencer. A pause request only turns into a stop when the sequencer is outside its critical section. The pause bit that the host reads back shows whether the sequencer has really halted, so the host polls that bit after it asks for a pause.

Four interrupt sources are collected into a status register:
- a sequencer event that comes with a reason code;
- command completion;
- a SCSI-side interrupt;
- a hard error or breakpoint. Its individual error flags are kept in a separate error register.

A sequencer event also pauses the sequencer. The sequencer stays paused until the host writes the control register with the pause bit cleared. A write-one-to-clear port removes pending sources. A single interrupt output is driven either as a level or as a one-cycle pulse for each new source.

Top module: `host_irq_ctrl`

## Requirements
- R1: The control register holds the following fields, and writes to it read back as below.
  - bit0 chip reset, bit1 interrupt enable, bit3 interrupt-line mode, bit4 software interrupt, bit6 power-down.
  - Bits 5 and 7 always read 0.
  - Bit2 reads the sequencer's actual halted state, not the written pause value.
- R2: While the sequencer signals a critical section, a pause request does not raise the stop output. The stop output rises on the cycle after the critical section ends. The read pause bit follows the halted input.
- R3: Writing the control register with bit2 clear (and bit0 clear) drops the stop output, so the sequencer resumes.
- R4: A sequencer event strobe has three effects:
  - It sets status bit0.
  - It stores its 4-bit reason code in status bits 7:4, if no event was already pending.
  - It sets the pause request, so the sequencer halts even though the host did not ask.
- R5: A command-complete strobe sets status bit1. Writing 1 to clear-bit1 removes it, unless the completion-queue-not-empty input is high; in that case bit1 stays set.
- R6: A SCSI-side interrupt sets status bit2. Writing 1 to clear-bit2 removes it only while the sequencer is not halted. While halted, the clear has no effect.
- R7: Each error flag pulse is ORed into the error register (bits 3:0) and sets status bit3. Writing 1 to clear-bit3 clears both the error register and status bit3.
- R8: The clear register works as follows:
  - Clear-bit0 removes status bit0 and the reason code.
  - Clear-bit1 and clear-bit3 act as stated above.
  - Bits 7:4 of a clear write have no effect.
- R9: With interrupt enable and line mode (bit3) set, the interrupt output is high one cycle after any of status bits 3:0 or the software interrupt bit is set. It stays high while any of them remains set.
- R10: With interrupt enable set and line mode clear, the interrupt output gives a one-cycle pulse one cycle after a source becomes newly set. It then returns low even though the source is still pending.
- R11: While control bit0 (chip reset) is set, the following hold:
  - The status and error registers are cleared on the next cycle.
  - Interrupt enable is held at 0.
  - The stop output is forced high, whatever the critical-section input says.
  - After the block's own reset, the pause request is set and interrupt enable is clear.
- R12: With interrupt enable clear, the interrupt output stays low on the following cycle, whatever sources are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| clr_wr | input | 1 | Clear register write strobe |
| clr_wdata | input | 8 | Clear register write data (write one to clear) |
| ctl_rdata | output | 8 | Control register read value, bit2 = actual halted state |
| stat_rdata | output | 8 | Status: reason code in 7:4, pending sources in 3:0 |
| err_rdata | output | 4 | Latched hard-error flags |
| seq_stop | output | 1 | Stop request to the sequencer |
| seq_halted | input | 1 | Sequencer reports it has halted |
| seq_crit | input | 1 | Sequencer is inside a critical section |
| seq_evt | input | 1 | Sequencer event strobe |
| seq_evt_code | input | 4 | Event reason code |
| seq_cmd_done | input | 1 | Command-complete strobe |
| seq_qout_nz | input | 1 | Completion queue still holds entries |
| scsi_irq | input | 1 | SCSI-side interrupt request |
| seq_err | input | 4 | Hard-error / breakpoint flag pulses |
| irq | output | 1 | Interrupt output |

## Verification
The properties assume the following about the sequencer model:
- The halted input follows the stop output a cycle later.
- Event, completion and error strobes are single-cycle pulses that arrive independently of host writes.
- Nothing raises an event while the chip-reset bit is set.

The bench keeps to this by modelling the sequencer's halted flag as a register fed from the stop output. It drives each strobe for exactly one cycle on a falling edge, apart from the register writes. It raises the critical-section input only around a pause request, never around an event.

// File: rtl/hic_pkg.sv
// Shared field positions and types for the host pause and interrupt controller.
// Assumes an 8-bit host register width.
package hic_pkg;
    localparam int REG_W  = 8;
    localparam int NSRC   = 4;

    // control register bit positions
    localparam int C_RST   = 0;
    localparam int C_IE    = 1;
    localparam int C_PAUSE = 2;
    localparam int C_IRQMS = 3;
    localparam int C_SWI   = 4;
    localparam int C_PWRDN = 6;

    // status source bit positions
    localparam int S_EVT  = 0;
    localparam int S_CMD  = 1;
    localparam int S_SCSI = 2;
    localparam int S_ERR  = 3;

    typedef struct packed {
        logic pwrdn;
        logic swint;
        logic irqms;
        logic pause;
        logic ie;
        logic rst;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{pwrdn: 1'b0, swint: 1'b0, irqms: 1'b0,
                                   pause: 1'b1, ie: 1'b0, rst: 1'b0};
endpackage

// File: rtl/hic_ctl.sv
// Host control register and pause handshake.
// Assumes the sequencer holds seq_crit only while it runs; a stop already
// granted is kept regardless of seq_crit. Chip reset forces a stop.
module hic_ctl
    import hic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             evt,
    input  logic             crit,
    output ctl_t             ctl,
    output logic             stop
);
    ctl_t ctl_n;

    // next control value: host write, then event auto-pause, then reset forcing
    always_comb begin
        ctl_n = ctl;
        if (wr) begin
            ctl_n.rst   = wdata[C_RST];
            ctl_n.ie    = wdata[C_IE];
            ctl_n.pause = wdata[C_PAUSE];
            ctl_n.irqms = wdata[C_IRQMS];
            ctl_n.swint = wdata[C_SWI];
            ctl_n.pwrdn = wdata[C_PWRDN];
        end
        if (evt) begin
            ctl_n.pause = 1'b1;
        end
        if (ctl_n.rst) begin
            ctl_n.ie    = 1'b0;
            ctl_n.pause = 1'b1;
        end
    end

    // control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) ctl <= CTL_RESET;
        else        ctl <= ctl_n;
    end

    // stop grant: blocked by a critical section unless already stopped or in chip reset
    always_ff @(posedge clk) begin
        if (!rst_n) stop <= 1'b1;
        else        stop <= ctl.rst | (ctl.pause & (stop | ~crit));
    end
endmodule

// File: rtl/hic_status.sv
// Interrupt source collection with write-one-to-clear.
// Assumes strobes are single-cycle; a set and a clear in the same cycle keep the source set.
module hic_status
    import hic_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_rst,
    input  logic              halted,
    input  logic              evt,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              cmd_done,
    input  logic              qout_nz,
    input  logic              scsi_irq,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              clr_wr,
    input  logic [REG_W-1:0]  clr_data,
    output logic [NSRC-1:0]   pend,
    output logic [CODE_W-1:0] code,
    output logic [ERR_W-1:0]  err
);
    logic [NSRC-1:0] clr;
    logic            evt_q, cmd_q, scsi_q;

    // gate the clear strobes
    assign clr = clr_wr ? clr_data[NSRC-1:0] : '0;

    // sequencer event flag and its reason code
    always_ff @(posedge clk) begin
        if (!rst_n || chip_rst) begin
            evt_q <= 1'b0;
            code  <= '0;
        end else if (evt) begin
            evt_q <= 1'b1;
            if (!evt_q || clr[S_EVT]) code <= evt_code;
        end else if (clr[S_EVT]) begin
            evt_q <= 1'b0;
            code  <= '0;
        end
    end

    // command complete, re-armed on clear while the completion queue is not empty
    always_ff @(posedge clk) begin
        if (!rst_n || chip_rst)  cmd_q <= 1'b0;
        else if (cmd_done)       cmd_q <= 1'b1;
        else if (clr[S_CMD])     cmd_q <= qout_nz;
    end

    // SCSI-side interrupt, clearable only while the sequencer runs
    always_ff @(posedge clk) begin
        if (!rst_n || chip_rst)            scsi_q <= 1'b0;
        else if (scsi_irq)                 scsi_q <= 1'b1;
        else if (clr[S_SCSI] && !halted)   scsi_q <= 1'b0;
    end

    // hard-error flags accumulate until cleared
    always_ff @(posedge clk) begin
        if (!rst_n || chip_rst) err <= '0;
        else                    err <= (clr[S_ERR] ? '0 : err) | err_in;
    end

    assign pend = {(|err), scsi_q, cmd_q, evt_q};
endmodule

// File: rtl/hic_irq.sv
// Interrupt output generator: level or one-cycle pulse per newly set source.
// Assumes src is a registered vector; output lags a source change by one cycle.
module hic_irq #(
    parameter int NIN = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ie,
    input  logic           level_mode,
    input  logic [NIN-1:0] src,
    output logic           irq
);
    logic [NIN-1:0] src_d;

    // remember last source vector for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) src_d <= '0;
        else        src_d <= src;
    end

    // drive the line in the selected mode
    always_ff @(posedge clk) begin
        if (!rst_n)          irq <= 1'b0;
        else if (level_mode) irq <= ie & (|src);
        else                 irq <= ie & (|(src & ~src_d));
    end
endmodule

// File: rtl/host_irq_ctrl.sv
// Top of the host pause and interrupt controller.
// Assumes seq_halted is the sequencer's own report of having stopped.
module host_irq_ctrl
    import hic_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int ERR_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic [7:0]             ctl_wdata,
    input  logic                   clr_wr,
    input  logic [7:0]             clr_wdata,
    output logic [7:0]             ctl_rdata,
    output logic [NSRC+CODE_W-1:0] stat_rdata,
    output logic [ERR_W-1:0]       err_rdata,
    output logic                   seq_stop,
    input  logic                   seq_halted,
    input  logic                   seq_crit,
    input  logic                   seq_evt,
    input  logic [CODE_W-1:0]      seq_evt_code,
    input  logic                   seq_cmd_done,
    input  logic                   seq_qout_nz,
    input  logic                   scsi_irq,
    input  logic [ERR_W-1:0]       seq_err,
    output logic                   irq
);
    localparam int NIN = NSRC + 1;

    ctl_t              ctl;
    logic [NSRC-1:0]   pend;
    logic [CODE_W-1:0] code;

    hic_ctl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .evt   (seq_evt),
        .crit  (seq_crit),
        .ctl   (ctl),
        .stop  (seq_stop)
    );

    hic_status #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_rst (ctl.rst),
        .halted   (seq_halted),
        .evt      (seq_evt),
        .evt_code (seq_evt_code),
        .cmd_done (seq_cmd_done),
        .qout_nz  (seq_qout_nz),
        .scsi_irq (scsi_irq),
        .err_in   (seq_err),
        .clr_wr   (clr_wr),
        .clr_data (clr_wdata),
        .pend     (pend),
        .code     (code),
        .err      (err_rdata)
    );

    hic_irq #(.NIN(NIN)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ie         (ctl.ie),
        .level_mode (ctl.irqms),
        .src        ({ctl.swint, pend}),
        .irq        (irq)
    );

    // register read views
    assign ctl_rdata  = {1'b0, ctl.pwrdn, 1'b0, ctl.swint, ctl.irqms,
                         seq_halted, ctl.ie, ctl.rst};
    assign stat_rdata = {code, pend};
endmodule

// File: rtl/hic_chk.sv
// Checker for host_irq_ctrl, observing ports only. Bound to every instance.
module hic_chk #(
    parameter int CODE_W = 4,
    parameter int ERR_W  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          ctl_rdata,
    input logic [CODE_W+3:0]   stat_rdata,
    input logic [ERR_W-1:0]    err_rdata,
    input logic                seq_stop,
    input logic                seq_halted,
    input logic                seq_crit,
    input logic                seq_evt,
    input logic [CODE_W-1:0]   seq_evt_code,
    input logic [ERR_W-1:0]    seq_err,
    input logic                irq
);
    // R2: no new stop grant inside a critical section
    p_crit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_crit && !seq_stop && !ctl_rdata[0]) |=> !seq_stop);

    // R4: first event latches flag and code
    p_evt_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_evt && !stat_rdata[0] && !ctl_rdata[0]) |=>
        (stat_rdata[0] && stat_rdata[CODE_W+3:4] == $past(seq_evt_code)));

    // R6: SCSI status survives while halted
    p_scsi_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[2] && seq_halted && !ctl_rdata[0]) |=> stat_rdata[2]);

    // R7: error pulses are captured
    p_err_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|seq_err) && !ctl_rdata[0]) |=>
        (stat_rdata[3] && ((err_rdata & $past(seq_err)) == $past(seq_err))));

    // R11: chip reset wipes status and forces a stop
    p_chip_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[0] |=> (stat_rdata == '0 && err_rdata == '0 && seq_stop));

    // R12: interrupt enable gates the output
    p_ie_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[1] |=> !irq);
endmodule

bind host_irq_ctrl hic_chk #(.CODE_W(CODE_W), .ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_rdata    (ctl_rdata),
    .stat_rdata   (stat_rdata),
    .err_rdata    (err_rdata),
    .seq_stop     (seq_stop),
    .seq_halted   (seq_halted),
    .seq_crit     (seq_crit),
    .seq_evt      (seq_evt),
    .seq_evt_code (seq_evt_code),
    .seq_err      (seq_err),
    .irq          (irq)
);

// File: tb/host_irq_ctrl_bench.sv
module host_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, clr_wr = 1'b0;
    logic [7:0] ctl_wdata = '0, clr_wdata = '0;
    logic [7:0] ctl_rdata, stat_rdata;
    logic [3:0] err_rdata;
    logic       seq_stop;
    logic       seq_halted;
    logic       seq_crit = 1'b0, seq_evt = 1'b0, seq_cmd_done = 1'b0;
    logic       seq_qout_nz = 1'b0, scsi_irq = 1'b0;
    logic [3:0] seq_evt_code = '0, seq_err = '0;
    logic       irq;
    int n_checks = 0;
    int n_fail   = 0;

    // code (4) and expected status byte (8)
    localparam logic [11:0] VEC [6] = '{
        {4'd0, 8'h01}, {4'd1, 8'h11}, {4'd2, 8'h21},
        {4'd3, 8'h31}, {4'd4, 8'h41}, {4'd5, 8'h51}
    };

    always #4 clk = ~clk;

    // sequencer model: halts one cycle after being told to stop
    always_ff @(posedge clk) begin
        if (!rst_n) seq_halted <= 1'b0;
        else        seq_halted <= seq_stop;
    end

    host_irq_ctrl u_host_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .ctl_rdata(ctl_rdata), .stat_rdata(stat_rdata), .err_rdata(err_rdata),
        .seq_stop(seq_stop), .seq_halted(seq_halted), .seq_crit(seq_crit),
        .seq_evt(seq_evt), .seq_evt_code(seq_evt_code),
        .seq_cmd_done(seq_cmd_done), .seq_qout_nz(seq_qout_nz),
        .scsi_irq(scsi_irq), .seq_err(seq_err), .irq(irq)
    );

    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d; cyc(1); ctl_wr = 1'b0;
    endtask

    task automatic wr_clr(input logic [7:0] d);
        clr_wr = 1'b1; clr_wdata = d; cyc(1); clr_wr = 1'b0;
    endtask

    task automatic pulse_cmd();
        seq_cmd_done = 1'b1; cyc(1); seq_cmd_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(3);
        rst_n = 1'b1;
        // R11 reset state
        check("R11 stat after reset", stat_rdata, 8'h00);
        check("R11 err after reset", {4'h0, err_rdata}, 8'h00);
        check("R11 irq after reset", {7'h0, irq}, 8'h00);
        check("R11 stop after reset", {7'h0, seq_stop}, 8'h01);
        cyc(2);
        check("R11 ctl after reset", ctl_rdata, 8'h04);

        // R3 unpause
        wr_ctl(8'h0A);
        cyc(2);
        check("R3 unpaused ctl", ctl_rdata, 8'h0A);

        // table walk over reason codes: R4, R8, R9, R3
        for (int i = 0; i < 6; i++) begin
            seq_evt = 1'b1; seq_evt_code = VEC[i][11:8];
            cyc(1);
            seq_evt = 1'b0;
            check("R4 status with code", stat_rdata, VEC[i][7:0]);
            cyc(1);
            check("R9 level irq on event", {7'h0, irq}, 8'h01);
            cyc(1);
            check("R4 auto-pause halted", {7'h0, ctl_rdata[2]}, 8'h01);
            wr_clr(8'h01);
            check("R8 event and code cleared", stat_rdata, 8'h00);
            cyc(1);
            check("R9 irq drops after clear", {7'h0, irq}, 8'h00);
            wr_ctl(8'h0A);
            cyc(2);
            check("R3 resumed after unpause", ctl_rdata, 8'h0A);
        end

        // R1 readback with unused bits written
        wr_ctl(8'hFA);
        check("R1 readback", ctl_rdata, 8'h5A);
        cyc(1);
        check("R9 software interrupt level", {7'h0, irq}, 8'h01);
        wr_ctl(8'h18);
        cyc(1);
        check("R12 irq masked without enable", {7'h0, irq}, 8'h00);
        wr_ctl(8'h0A);

        // R5 command complete with queue re-arm
        pulse_cmd();
        check("R5 cmd set", stat_rdata, 8'h02);
        seq_qout_nz = 1'b1;
        wr_clr(8'h02);
        check("R5 cmd re-armed by queue", stat_rdata, 8'h02);
        seq_qout_nz = 1'b0;
        // R8 upper clear bits have no effect
        wr_clr(8'hF0);
        check("R8 upper clear bits ignored", stat_rdata, 8'h02);
        wr_clr(8'h02);
        check("R5 cmd cleared", stat_rdata, 8'h00);

        // R7 error accumulation
        seq_err = 4'b0101; cyc(1); seq_err = 4'b0010; cyc(1); seq_err = 4'b0000;
        check("R7 err register", {4'h0, err_rdata}, 8'h07);
        check("R7 status bit3", stat_rdata, 8'h08);
        wr_clr(8'h08);
        check("R7 err cleared", {4'h0, err_rdata}, 8'h00);
        check("R7 status bit3 cleared", stat_rdata, 8'h00);

        // R10 pulse mode
        wr_ctl(8'h02);
        cyc(1);
        pulse_cmd();
        cyc(1);
        check("R10 pulse high", {7'h0, irq}, 8'h01);
        cyc(1);
        check("R10 pulse low", {7'h0, irq}, 8'h00);
        check("R10 source still pending", stat_rdata, 8'h02);
        wr_clr(8'h02);
        wr_ctl(8'h0A);

        // R2 critical section holds off pause
        seq_crit = 1'b1;
        wr_ctl(8'h0E);
        cyc(3);
        check("R2 not halted in critical section", {7'h0, ctl_rdata[2]}, 8'h00);
        check("R2 stop held off", {7'h0, seq_stop}, 8'h00);
        seq_crit = 1'b0;
        cyc(2);
        check("R2 halted after critical section", {7'h0, ctl_rdata[2]}, 8'h01);

        // R6 SCSI clear gated by pause
        scsi_irq = 1'b1; cyc(1); scsi_irq = 1'b0;
        check("R6 scsi set", stat_rdata, 8'h04);
        wr_clr(8'h04);
        check("R6 clear ignored while halted", stat_rdata, 8'h04);
        wr_ctl(8'h0A);
        cyc(2);
        wr_clr(8'h04);
        check("R6 clear while running", stat_rdata, 8'h00);

        // R11 chip reset
        pulse_cmd();
        wr_ctl(8'h03);
        cyc(1);
        check("R11 chip reset clears status", stat_rdata, 8'h00);
        check("R11 chip reset enable low", {7'h0, ctl_rdata[1]}, 8'h00);
        check("R11 chip reset forces stop", {7'h0, seq_stop}, 8'h01);
        wr_ctl(8'h0A);
        cyc(2);
        check("R11 leaves reset", ctl_rdata, 8'h0A);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule